// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one storage cell of a programmable logic array. It takes a single sum-of-products term and passes it through an XOR stage whose second input is a configuration bit. The result goes to a storage element that static configuration sets up as an edge-triggered D register, a transparent D latch or a toggle flip-flop. The storage element's clock, clock enable, preset and reset are each picked from several candidate sources. Each of these four controls has its own polarity bit.

The cell has two outputs. One feeds back into the local logic and the other drives the interconnect. Each output has its own select bit that picks either the stored value or the combinatorial post-XOR value. This lets one cell carry a registered function and an unrelated combinatorial function at the same time. The configuration inputs are meant to be held static during operation and changed only while the cell is idle.

Top module: `pld_macrocell`

## Requirements
- R1: The combinatorial value is `sop_i XOR cfg_xor_i`, and any output set to combinatorial shows it without any clock.
- R2: In D register mode (`cfg_mode_i` = 0), an active clock edge with the enable active stores the combinatorial value.
- R3: In toggle mode (`cfg_mode_i` = 2), an enabled active edge inverts the stored value when the combinatorial value is 1 and keeps it when it is 0.
- R4: In latch mode (`cfg_mode_i` = 1), the stored value follows the combinatorial value while the selected clock is at its active level and the enable is active, and holds while the clock is at its inactive level.
- R5: `cfg_clk_src_i` picks the clock: 0 is global clock `gclk_i[cfg_gclk_idx_i]`, 1 is local clock `lclk_i[cfg_lclk_idx_i]`, 2 is `ptclk_i` and 3 is `shclk_i`. Edges on clocks that are not selected have no effect.
- R6: With `cfg_clk_inv_i` = 1, the active clock edge is the falling edge of the source and the active latch level is low. With 0, the active edge is the rising edge and the active level is high.
- R7: `cfg_ce_src_i` picks the enable: 0 is `gce_i`, 1 is `lce_i`, 2 is `ptce_i` and 3 is always enabled. An active edge while the enable is inactive leaves the stored value unchanged.
- R8: Preset forces a 1 and reset forces a 0. Both act asynchronously and both override the enable, and reset wins over preset. `cfg_set_src_i` and `cfg_rst_src_i` pick 0 for the global line or 1 for the product-term line, and the line that is not selected has no effect.
- R9: `cfg_ce_inv_i`, `cfg_set_inv_i` and `cfg_rst_inv_i` make the enable, preset and reset active low. With the bit at 0, the control is active high.
- R10: `cfg_fb_reg_i` and `cfg_ic_reg_i` independently pick, for `fb_o` and `ic_o`, the stored value (1) or the combinatorial value (0).
- R11: Mode code 3 behaves exactly as D register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | NUM_GCLK | Global clock lines |
| lclk_i | input | NUM_LCLK | Local clock lines |
| ptclk_i | input | 1 | Product-term clock |
| shclk_i | input | 1 | Shared product-term clock |
| gce_i | input | 1 | Global clock enable |
| lce_i | input | 1 | Local clock enable |
| ptce_i | input | 1 | Product-term clock enable |
| gset_i | input | 1 | Global preset |
| ptset_i | input | 1 | Product-term preset |
| grst_i | input | 1 | Global reset |
| ptrst_i | input | 1 | Product-term reset |
| sop_i | input | 1 | Sum-of-products data input |
| cfg_mode_i | input | 2 | Storage mode: 0 D register, 1 latch, 2 toggle, 3 D register |
| cfg_xor_i | input | 1 | XOR stage configuration bit |
| cfg_clk_src_i | input | 2 | Clock source select |
| cfg_gclk_idx_i | input | GIDX_W | Global clock index |
| cfg_lclk_idx_i | input | LIDX_W | Local clock index |
| cfg_ce_src_i | input | 2 | Enable source select |
| cfg_set_src_i | input | 1 | Preset source: 0 global, 1 product term |
| cfg_rst_src_i | input | 1 | Reset source: 0 global, 1 product term |
| cfg_clk_inv_i | input | 1 | Clock polarity |
| cfg_ce_inv_i | input | 1 | Enable polarity |
| cfg_set_inv_i | input | 1 | Preset polarity |
| cfg_rst_inv_i | input | 1 | Reset polarity |
| cfg_fb_reg_i | input | 1 | Feedback output: 1 stored, 0 combinatorial |
| cfg_ic_reg_i | input | 1 | Interconnect output: 1 stored, 0 combinatorial |
| fb_o | output | 1 | Local feedback output |
| ic_o | output | 1 | Interconnect output |

## Verification
The cell has no clock of its own. A combinatorial output and the effect of preset or reset are due as soon as the inputs settle, with no clock needed. In latch mode the output follows the data within the same settling interval. In register and toggle modes, the stored output is due right after the active edge of the selected clock, one register stage from the data. The bench therefore changes one input or one clock line at a time and samples the outputs 1 ns after that change. The clock line is then returned to its idle level before the next step, so every expected value in the scoreboard matches exactly one stimulus.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    typedef enum logic [1:0] {
        MODE_DREG   = 2'd0,
        MODE_LATCH  = 2'd1,
        MODE_TOGGLE = 2'd2,
        MODE_SPARE  = 2'd3
    } store_mode_e;

    typedef enum logic [1:0] {
        CLK_GLOBAL = 2'd0,
        CLK_LOCAL  = 2'd1,
        CLK_PTERM  = 2'd2,
        CLK_SHARED = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        CE_GLOBAL = 2'd0,
        CE_LOCAL  = 2'd1,
        CE_PTERM  = 2'd2,
        CE_ALWAYS = 2'd3
    } ce_src_e;

    // resolved, polarity-corrected control set for the storage element
    typedef struct packed {
        logic eclk;
        logic ce;
        logic set;
        logic rst;
    } ctrl_t;

    typedef struct packed {
        logic flop;
    } store_t;

endpackage

// File: rtl/mcell_ctrl_sel.sv
module mcell_ctrl_sel
    import mcell_pkg::*;
#(
    parameter int NUM_GCLK = 4,
    parameter int NUM_LCLK = 2,
    localparam int GIDX_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1,
    localparam int LIDX_W = (NUM_LCLK > 1) ? $clog2(NUM_LCLK) : 1
) (
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic [NUM_LCLK-1:0] lclk_i,
    input  logic                ptclk_i,
    input  logic                shclk_i,
    input  logic                gce_i,
    input  logic                lce_i,
    input  logic                ptce_i,
    input  logic                gset_i,
    input  logic                ptset_i,
    input  logic                grst_i,
    input  logic                ptrst_i,
    input  clk_src_e            clk_src_i,
    input  logic [GIDX_W-1:0]   gclk_idx_i,
    input  logic [LIDX_W-1:0]   lclk_idx_i,
    input  ce_src_e             ce_src_i,
    input  logic                set_src_i,
    input  logic                rst_src_i,
    input  logic                clk_inv_i,
    input  logic                ce_inv_i,
    input  logic                set_inv_i,
    input  logic                rst_inv_i,
    output ctrl_t               ctrl_o
);

    logic   gclk_pick;
    logic   lclk_pick;
    logic   clk_raw;
    logic   ce_raw;
    ctrl_t  ctrl_d;

    // out-of-range indices select an idle line
    always_comb begin
        gclk_pick = 1'b0;
        for (int g = 0; g < NUM_GCLK; g++) begin
            if (int'(gclk_idx_i) == g) gclk_pick = gclk_i[g];
        end
        lclk_pick = 1'b0;
        for (int l = 0; l < NUM_LCLK; l++) begin
            if (int'(lclk_idx_i) == l) lclk_pick = lclk_i[l];
        end
    end

    always_comb begin
        unique case (clk_src_i)
            CLK_GLOBAL: clk_raw = gclk_pick;
            CLK_LOCAL:  clk_raw = lclk_pick;
            CLK_PTERM:  clk_raw = ptclk_i;
            default:    clk_raw = shclk_i;
        endcase

        unique case (ce_src_i)
            CE_GLOBAL: ce_raw = gce_i;
            CE_LOCAL:  ce_raw = lce_i;
            CE_PTERM:  ce_raw = ptce_i;
            default:   ce_raw = ~ce_inv_i;
        endcase

        ctrl_d.eclk = clk_raw ^ clk_inv_i;
        ctrl_d.ce   = ce_raw ^ ce_inv_i;
        ctrl_d.set  = (set_src_i ? ptset_i : gset_i) ^ set_inv_i;
        ctrl_d.rst  = (rst_src_i ? ptrst_i : grst_i) ^ rst_inv_i;
    end

    assign ctrl_o = ctrl_d;

endmodule

// File: rtl/mcell_store.sv
module mcell_store
    import mcell_pkg::*;
(
    input  ctrl_t       ctrl_i,
    input  store_mode_e mode_i,
    input  logic        d_i,
    output logic        q_o
);

    store_t st_d;
    store_t st_q;
    logic   lat_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_i.ce) begin
            if (mode_i == MODE_TOGGLE) st_d.flop = st_q.flop ^ d_i;
            else                       st_d.flop = d_i;
        end
    end

    always_ff @(posedge ctrl_i.eclk or posedge ctrl_i.rst or posedge ctrl_i.set) begin
        if (ctrl_i.rst)      st_q <= '0;
        else if (ctrl_i.set) st_q <= '{flop: 1'b1};
        else                 st_q <= st_d;
    end

    always_latch begin
        if (ctrl_i.rst)                    lat_q <= 1'b0;
        else if (ctrl_i.set)               lat_q <= 1'b1;
        else if (ctrl_i.eclk && ctrl_i.ce) lat_q <= d_i;
    end

    assign q_o = (mode_i == MODE_LATCH) ? lat_q : st_q.flop;

    // R2 / R11: enabled edge outside toggle and latch modes stores the data
    p_dcapture_r2: assert property (@(posedge ctrl_i.eclk) disable iff (ctrl_i.rst || ctrl_i.set)
        (ctrl_i.ce && mode_i != MODE_TOGGLE && mode_i != MODE_LATCH) |=> (st_q.flop == $past(d_i)))
        else $error("p_dcapture_r2");

    // R3: enabled edge with data 1 in toggle mode flips the state
    p_toggle_r3: assert property (@(posedge ctrl_i.eclk) disable iff (ctrl_i.rst || ctrl_i.set)
        (ctrl_i.ce && mode_i == MODE_TOGGLE && d_i) |=> (st_q.flop != $past(st_q.flop)))
        else $error("p_toggle_r3");

    // R7: an edge without enable keeps the state
    p_hold_r7: assert property (@(posedge ctrl_i.eclk) disable iff (ctrl_i.rst || ctrl_i.set)
        !ctrl_i.ce |=> $stable(st_q.flop))
        else $error("p_hold_r7");

    // R8: while preset is held and reset is not, clock edges see a 1
    p_preset_r8: assert property (@(posedge ctrl_i.eclk) disable iff (ctrl_i.rst)
        ctrl_i.set |-> (st_q.flop == 1'b1))
        else $error("p_preset_r8");

endmodule

// File: rtl/mcell_out_sel.sv
module mcell_out_sel #(
    parameter int NUM_OUT = 2
) (
    input  logic               stored_i,
    input  logic               comb_i,
    input  logic [NUM_OUT-1:0] reg_sel_i,
    output logic [NUM_OUT-1:0] out_o
);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        assign out_o[k] = reg_sel_i[k] ? stored_i : comb_i;
    end

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import mcell_pkg::*;
#(
    parameter int NUM_GCLK = 4,
    parameter int NUM_LCLK = 2,
    localparam int GIDX_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1,
    localparam int LIDX_W = (NUM_LCLK > 1) ? $clog2(NUM_LCLK) : 1
) (
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic [NUM_LCLK-1:0] lclk_i,
    input  logic                ptclk_i,
    input  logic                shclk_i,
    input  logic                gce_i,
    input  logic                lce_i,
    input  logic                ptce_i,
    input  logic                gset_i,
    input  logic                ptset_i,
    input  logic                grst_i,
    input  logic                ptrst_i,
    input  logic                sop_i,
    input  logic [1:0]          cfg_mode_i,
    input  logic                cfg_xor_i,
    input  logic [1:0]          cfg_clk_src_i,
    input  logic [GIDX_W-1:0]   cfg_gclk_idx_i,
    input  logic [LIDX_W-1:0]   cfg_lclk_idx_i,
    input  logic [1:0]          cfg_ce_src_i,
    input  logic                cfg_set_src_i,
    input  logic                cfg_rst_src_i,
    input  logic                cfg_clk_inv_i,
    input  logic                cfg_ce_inv_i,
    input  logic                cfg_set_inv_i,
    input  logic                cfg_rst_inv_i,
    input  logic                cfg_fb_reg_i,
    input  logic                cfg_ic_reg_i,
    output logic                fb_o,
    output logic                ic_o
);

    localparam int NUM_OUT = 2;

    ctrl_t              ctrl;
    logic               xor_d;
    logic               stored_q;
    logic [NUM_OUT-1:0] outs;

    assign xor_d = sop_i ^ cfg_xor_i;

    mcell_ctrl_sel #(
        .NUM_GCLK (NUM_GCLK),
        .NUM_LCLK (NUM_LCLK)
    ) i_ctrl (
        .gclk_i     (gclk_i),
        .lclk_i     (lclk_i),
        .ptclk_i    (ptclk_i),
        .shclk_i    (shclk_i),
        .gce_i      (gce_i),
        .lce_i      (lce_i),
        .ptce_i     (ptce_i),
        .gset_i     (gset_i),
        .ptset_i    (ptset_i),
        .grst_i     (grst_i),
        .ptrst_i    (ptrst_i),
        .clk_src_i  (clk_src_e'(cfg_clk_src_i)),
        .gclk_idx_i (cfg_gclk_idx_i),
        .lclk_idx_i (cfg_lclk_idx_i),
        .ce_src_i   (ce_src_e'(cfg_ce_src_i)),
        .set_src_i  (cfg_set_src_i),
        .rst_src_i  (cfg_rst_src_i),
        .clk_inv_i  (cfg_clk_inv_i),
        .ce_inv_i   (cfg_ce_inv_i),
        .set_inv_i  (cfg_set_inv_i),
        .rst_inv_i  (cfg_rst_inv_i),
        .ctrl_o     (ctrl)
    );

    mcell_store i_store (
        .ctrl_i (ctrl),
        .mode_i (store_mode_e'(cfg_mode_i)),
        .d_i    (xor_d),
        .q_o    (stored_q)
    );

    mcell_out_sel #(
        .NUM_OUT (NUM_OUT)
    ) i_outs (
        .stored_i  (stored_q),
        .comb_i    (xor_d),
        .reg_sel_i ({cfg_ic_reg_i, cfg_fb_reg_i}),
        .out_o     (outs)
    );

    assign fb_o = outs[0];
    assign ic_o = outs[1];

endmodule

// File: tb/test_pld_macrocell.sv
module test_pld_macrocell;

    logic       clk = 1'b0;
    logic [3:0] gclk = '0;
    logic [1:0] lclk = '0;
    logic ptclk = 0, shclk = 0, gce = 0, lce = 0, ptce = 0;
    logic gset = 0, ptset = 0, grst = 1, ptrst = 0, sop = 0;
    logic [1:0] mode = 2'd0, clk_src = 2'd0, ce_src = 2'd3;
    logic [1:0] gidx = '0;
    logic       lidx = 1'b0;
    logic xr = 0, set_src = 0, rst_src = 0;
    logic clk_inv = 0, ce_inv = 0, set_inv = 0, rst_inv = 0;
    logic fb_reg = 1, ic_reg = 0;
    logic fb, ic;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];
    event       sb_ev;

    always #2.5 clk = ~clk;

    pld_macrocell i_pld_macrocell (
        .gclk_i(gclk), .lclk_i(lclk), .ptclk_i(ptclk), .shclk_i(shclk),
        .gce_i(gce), .lce_i(lce), .ptce_i(ptce),
        .gset_i(gset), .ptset_i(ptset), .grst_i(grst), .ptrst_i(ptrst),
        .sop_i(sop), .cfg_mode_i(mode), .cfg_xor_i(xr),
        .cfg_clk_src_i(clk_src), .cfg_gclk_idx_i(gidx), .cfg_lclk_idx_i(lidx),
        .cfg_ce_src_i(ce_src), .cfg_set_src_i(set_src), .cfg_rst_src_i(rst_src),
        .cfg_clk_inv_i(clk_inv), .cfg_ce_inv_i(ce_inv),
        .cfg_set_inv_i(set_inv), .cfg_rst_inv_i(rst_inv),
        .cfg_fb_reg_i(fb_reg), .cfg_ic_reg_i(ic_reg),
        .fb_o(fb), .ic_o(ic)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (exp_q.size() > 0) begin
                logic [1:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({fb, ic} !== e) begin
                    n_errors++;
                    $display("FAIL %s: fb/ic actual=%b%b expected=%b%b", t, fb, ic, e[1], e[0]);
                end
            end
        end
    end

    // driver side: outputs are sampled 1 ns after the last input change
    task automatic expect_out(input logic efb, input logic eic, input string t);
        #1;
        exp_q.push_back({efb, eic});
        tag_q.push_back(t);
        ->sb_ev;
        #1;
    endtask

    task automatic drive_src(input int which, input logic v);
        case (which)
            0, 1, 2, 3: gclk[which] = v;
            4, 5:       lclk[which-4] = v;
            6:          ptclk = v;
            default:    shclk = v;
        endcase
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        drive_src(which, 1'b1);
        #1;
        drive_src(which, 1'b0);
    endtask

    initial begin
        #3;
        expect_out(0, 0, "R8 reset state");
        grst = 0;
        // R1 combinatorial path
        sop = 1; expect_out(0, 1, "R1 xor off");
        xr = 1;  expect_out(0, 0, "R1 xor on");
        xr = 0;
        // R2 D register
        pulse(0); expect_out(1, 1, "R2 capture 1");
        sop = 0; pulse(0); expect_out(0, 0, "R2 capture 0");
        xr = 1; pulse(0); expect_out(1, 1, "R2 capture inverted data");
        xr = 0;
        // R5 clock source selection
        gidx = 2'd2; pulse(0); expect_out(1, 0, "R5 unselected global clock ignored");
        pulse(2); expect_out(0, 0, "R5 global clock index 2");
        clk_src = 2'd1; lidx = 1'b1; sop = 1;
        pulse(4); expect_out(0, 1, "R5 unselected local clock ignored");
        pulse(5); expect_out(1, 1, "R5 local clock index 1");
        clk_src = 2'd2; sop = 0;
        pulse(5); expect_out(1, 0, "R5 local ignored under pterm clock");
        pulse(6); expect_out(0, 0, "R5 pterm clock");
        clk_src = 2'd3; sop = 1;
        pulse(6); expect_out(0, 1, "R5 pterm ignored under shared clock");
        pulse(7); expect_out(1, 1, "R5 shared clock");
        // R6 inverted clock
        clk_src = 2'd0; gidx = 2'd0; clk_inv = 1;
        #1; sop = 0;
        @(negedge clk); gclk[0] = 1; expect_out(1, 0, "R6 rising source edge ignored");
        gclk[0] = 0; expect_out(0, 0, "R6 falling source edge captures");
        clk_inv = 0;
        // R7 / R9 enable
        ce_src = 2'd0; gce = 0; sop = 1;
        pulse(0); expect_out(0, 1, "R7 global enable low holds");
        gce = 1; pulse(0); expect_out(1, 1, "R7 global enable high captures");
        ce_inv = 1; sop = 0;
        pulse(0); expect_out(1, 0, "R9 inverted enable high holds");
        gce = 0; pulse(0); expect_out(0, 0, "R9 inverted enable low captures");
        ce_inv = 0;
        ce_src = 2'd1; lce = 0; sop = 1;
        pulse(0); expect_out(0, 1, "R7 local enable low holds");
        lce = 1; pulse(0); expect_out(1, 1, "R7 local enable high captures");
        ce_src = 2'd2; ptce = 0; sop = 0;
        pulse(0); expect_out(1, 0, "R7 pterm enable low holds");
        ptce = 1; pulse(0); expect_out(0, 0, "R7 pterm enable high captures");
        ce_src = 2'd3;
        // R3 toggle
        mode = 2'd2; sop = 1;
        pulse(0); expect_out(1, 1, "R3 toggle to 1");
        pulse(0); expect_out(0, 1, "R3 toggle to 0");
        pulse(0); expect_out(1, 1, "R3 toggle to 1 again");
        sop = 0; pulse(0); expect_out(1, 0, "R3 data 0 holds");
        xr = 1; pulse(0); expect_out(0, 1, "R3 inverted data toggles");
        xr = 0;
        // R4 latch
        mode = 2'd1; sop = 1;
        @(negedge clk); gclk[0] = 1; expect_out(1, 1, "R4 transparent high");
        sop = 0; expect_out(0, 0, "R4 follows data");
        sop = 1; expect_out(1, 1, "R4 follows data back");
        gclk[0] = 0; expect_out(1, 1, "R4 closes on low level");
        sop = 0; expect_out(1, 0, "R4 holds while closed");
        gclk[0] = 1; #1; gclk[0] = 0; expect_out(0, 0, "R4 reopen captures 0");
        // R8 preset and reset sources
        mode = 2'd0;
        grst = 1; expect_out(0, 0, "R8 global reset clears");
        grst = 0;
        set_src = 1; gset = 1; expect_out(0, 0, "R8 unselected global preset ignored");
        gset = 0; ptset = 1; expect_out(1, 0, "R8 pterm preset sets");
        ptset = 0; expect_out(1, 0, "R8 preset released holds");
        rst_src = 1; grst = 1; expect_out(1, 0, "R8 unselected global reset ignored");
        grst = 0; ptrst = 1; expect_out(0, 0, "R8 pterm reset clears");
        ptset = 1; expect_out(0, 0, "R8 reset wins over preset");
        ptset = 0; ptrst = 0; expect_out(0, 0, "R8 both released");
        ce_src = 2'd0; gce = 0;
        ptset = 1; expect_out(1, 0, "R8 preset overrides disabled enable");
        ptset = 0; ptrst = 1; expect_out(0, 0, "R8 reset overrides disabled enable");
        ptrst = 0; ce_src = 2'd3;
        // R9 preset and reset polarity
        set_inv = 1; expect_out(1, 0, "R9 active-low preset");
        set_inv = 0; rst_inv = 1; expect_out(0, 0, "R9 active-low reset");
        rst_inv = 0;
        // R10 output selection
        sop = 1; expect_out(0, 1, "R10 fb stored ic comb");
        fb_reg = 0; ic_reg = 1; expect_out(1, 0, "R10 fb comb ic stored");
        fb_reg = 1; expect_out(0, 0, "R10 both stored");
        ic_reg = 0;
        // R11 spare mode acts as D
        mode = 2'd3;
        pulse(0); expect_out(1, 1, "R11 captures 1");
        pulse(0); expect_out(1, 1, "R11 no toggle");
        sop = 0; pulse(0); expect_out(0, 0, "R11 captures 0");
        #5;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule